// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block sits at the point where a processor core commits to taking an exception or an interrupt. It is given a single-cycle trap strobe and the facts about the trap: whether it is an interrupt, its raw cause code, and whether it comes from an address translation failure (with the access kind and whether translation is enabled). It is also given the faulting address, the current PC and privilege, the two delegation masks, the two trap vectors and the current status word. One clock later it presents the complete new architectural state: the next PC and privilege, the cause word, the saved exception PC, the trap value and the rewritten status word.

The raw cause is first resolved. An environment call is recoded by the privilege it came from. A translation failure becomes a page-fault or access-fault code for fetch, load or store. The resolved code then indexes the exception or the interrupt delegation mask, which selects supervisor or machine handling. A small state machine records which handler level took the most recent trap. Its states are IDLE (no trap this cycle), SUP_TAKEN (a supervisor trap was committed) and MACH_TAKEN (a machine trap was committed). Every cycle with a strobe moves it to SUP_TAKEN or MACH_TAKEN according to the routing decision. Every cycle without one returns it to IDLE.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset `out_valid` and `out_to_super` are 0, `next_priv` is 3 (machine), and `next_pc`, `cause_out`, `epc_out`, `tval_out` and `status_out` are all zero.
- R2: All outputs are registered. A strobe on `trap_valid` at one rising edge makes the results visible after that edge, and `out_valid` is high for exactly the cycles that follow a strobe. Without a strobe, the result registers keep their values.
- R3: For an interrupt, `cause_out` has bit XLEN-1 set and the cause code in its low bits. For an exception, bit XLEN-1 is clear.
- R4: An exception with code 8 (environment call) is recoded by the current privilege (0 user, 1 supervisor, 2 reserved, 3 machine) to 8, 9, 10 or 11 respectively. Any other code passes unchanged.
- R5: When `xlat_fault` is set on an exception, the code comes from `xlat_kind` (0 fetch, 1 load, 2 or 3 store). With `xlat_on` = 1 the codes are 12, 13 and 15. With `xlat_on` = 0 they are 1, 5 and 7. `trap_code` is ignored in this case.
- R6: Exceptions are routed by `exc_deleg` and interrupts by `irq_deleg`, each indexed by the resolved code. The trap goes to supervisor (`out_to_super` = 1) only when `cur_priv` is 0 or 1 and the selected bit is set. Otherwise it goes to machine.
- R7: On a supervisor trap, `next_pc` = `stvec` and `next_priv` = 1. In `status_out`, bit 5 takes the old bit 1, bit 8 takes bit 0 of the old privilege and bit 1 is cleared. All other bits are unchanged.
- R8: On a machine trap, `next_pc` = `mtvec` and `next_priv` = 3. In `status_out`, bit 7 takes the old bit 3, bits 12:11 take the old privilege and bit 3 is cleared. All other bits are unchanged.
- R9: `epc_out` holds the `cur_pc` sampled with the strobe.
- R10: `tval_out` holds `fault_addr` only for exceptions whose resolved code is 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for every interrupt, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Commit a trap this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Raw cause code |
| xlat_fault | input | 1 | Exception is a translation failure |
| xlat_on | input | 1 | Translation enabled (not bare) |
| xlat_kind | input | 2 | Access kind: 0 fetch, 1 load, 2/3 store |
| fault_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| status_in | input | XLEN | Current status word |
| out_valid | output | 1 | Results below belong to a trap just taken |
| out_to_super | output | 1 | Trap handled in supervisor mode |
| next_pc | output | XLEN | New PC |
| next_priv | output | 2 | New privilege |
| cause_out | output | XLEN | Cause word for the target level |
| epc_out | output | XLEN | Exception PC for the target level |
| tval_out | output | XLEN | Trap value for the target level |
| status_out | output | XLEN | Rewritten status word |

## Verification
The bench builds the block with its default XLEN of 64, so CODE_W is 6. Every cause code up to 63 can then index the delegation masks, and the interrupt flag lands in bit 63 of the cause word. At this width, full-width address and PC patterns show that the trap value and the exception PC keep every bit, including the sign-extended upper half. They also show that the status word keeps all the bits the trap must not touch.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_AMO   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SUP_TAKEN  = 2'd1,
        ST_MACH_TAKEN = 2'd2
    } trap_state_e;

    // status word field positions decoded by the rest of the core
    localparam int SB_SIE  = 1;
    localparam int SB_MIE  = 3;
    localparam int SB_SPIE = 5;
    localparam int SB_MPIE = 7;
    localparam int SB_SPP  = 8;
    localparam int SB_MPP  = 11;

    // architectural cause codes
    localparam int C_FETCH_MIS  = 0;
    localparam int C_FETCH_ACC  = 1;
    localparam int C_LOAD_MIS   = 4;
    localparam int C_LOAD_ACC   = 5;
    localparam int C_STORE_MIS  = 6;
    localparam int C_STORE_ACC  = 7;
    localparam int C_ECALL_BASE = 8;
    localparam int C_FETCH_PF   = 12;
    localparam int C_LOAD_PF    = 13;
    localparam int C_STORE_PF   = 15;

endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
    import trap_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              xlat_fault,
    input  logic              xlat_on,
    input  logic [1:0]        xlat_kind,
    input  logic [1:0]        cur_priv,
    output logic [CODE_W-1:0] code_res,
    output logic [XLEN-1:0]   cause_word,
    output logic              addr_related
);

    logic [CODE_W-1:0] xlat_code;
    logic [CODE_W-1:0] exc_code;

    // translation failure: kind picks fetch/load/store, mode picks fault class
    always_comb begin
        unique case (acc_e'(xlat_kind))
            ACC_FETCH: xlat_code = xlat_on ? CODE_W'(C_FETCH_PF) : CODE_W'(C_FETCH_ACC);
            ACC_LOAD:  xlat_code = xlat_on ? CODE_W'(C_LOAD_PF)  : CODE_W'(C_LOAD_ACC);
            default:   xlat_code = xlat_on ? CODE_W'(C_STORE_PF) : CODE_W'(C_STORE_ACC);
        endcase
    end

    // environment call is recoded by the privilege it came from
    always_comb begin
        if (raw_code == CODE_W'(C_ECALL_BASE))
            exc_code = CODE_W'(C_ECALL_BASE) + CODE_W'(cur_priv);
        else
            exc_code = raw_code;
    end

    always_comb begin
        if (is_irq)
            code_res = raw_code;
        else if (xlat_fault)
            code_res = xlat_code;
        else
            code_res = exc_code;
    end

    always_comb begin
        cause_word               = '0;
        cause_word[CODE_W-1:0]   = code_res;
        cause_word[XLEN-1]       = is_irq;
    end

    // only address-bearing exceptions report the faulting address
    always_comb begin
        addr_related = 1'b0;
        if (!is_irq) begin
            unique case (int'(code_res))
                C_FETCH_MIS, C_FETCH_ACC, C_LOAD_MIS, C_LOAD_ACC,
                C_STORE_MIS, C_STORE_ACC, C_FETCH_PF, C_LOAD_PF,
                C_STORE_PF: addr_related = 1'b1;
                default:    addr_related = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code_res,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    output logic              go_super
);

    logic [XLEN-1:0] sel_mask;

    for (genvar i = 0; i < XLEN; i++) begin : g_mask_sel
        assign sel_mask[i] = is_irq ? irq_deleg[i] : exc_deleg[i];
    end

    logic low_priv;
    assign low_priv = (cur_priv == PRIV_USER) || (cur_priv == PRIV_SUPER);
    assign go_super = low_priv && sel_mask[code_res];

endmodule

// File: rtl/trap_status_update.sv
module trap_status_update
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] status_in,
    input  logic [1:0]      cur_priv,
    input  logic            go_super,
    output logic [XLEN-1:0] status_nx
);

    always_comb begin
        status_nx = status_in;
        if (go_super) begin
            status_nx[SB_SPIE] = status_in[SB_SIE];
            status_nx[SB_SPP]  = cur_priv[0];
            status_nx[SB_SIE]  = 1'b0;
        end else begin
            status_nx[SB_MPIE]          = status_in[SB_MIE];
            status_nx[SB_MPP+1:SB_MPP]  = cur_priv;
            status_nx[SB_MIE]           = 1'b0;
        end
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic              xlat_fault,
    input  logic              xlat_on,
    input  logic [1:0]        xlat_kind,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   stvec,
    input  logic [XLEN-1:0]   mtvec,
    input  logic [XLEN-1:0]   status_in,
    output logic              out_valid,
    output logic              out_to_super,
    output logic [XLEN-1:0]   next_pc,
    output logic [1:0]        next_priv,
    output logic [XLEN-1:0]   cause_out,
    output logic [XLEN-1:0]   epc_out,
    output logic [XLEN-1:0]   tval_out,
    output logic [XLEN-1:0]   status_out
);

    logic [CODE_W-1:0] code_res;
    logic [XLEN-1:0]   cause_word;
    logic              addr_related;
    logic              go_super;
    logic [XLEN-1:0]   status_nx;

    trap_cause_resolve #(.XLEN(XLEN)) u_cause (
        .is_irq       (trap_is_irq),
        .raw_code     (trap_code),
        .xlat_fault   (xlat_fault),
        .xlat_on      (xlat_on),
        .xlat_kind    (xlat_kind),
        .cur_priv     (cur_priv),
        .code_res     (code_res),
        .cause_word   (cause_word),
        .addr_related (addr_related)
    );

    trap_route #(.XLEN(XLEN)) u_route (
        .is_irq    (trap_is_irq),
        .code_res  (code_res),
        .cur_priv  (cur_priv),
        .exc_deleg (exc_deleg),
        .irq_deleg (irq_deleg),
        .go_super  (go_super)
    );

    trap_status_update #(.XLEN(XLEN)) u_status (
        .status_in (status_in),
        .cur_priv  (cur_priv),
        .go_super  (go_super),
        .status_nx (status_nx)
    );

    trap_state_e state_q, state_nx;

    always_comb begin
        unique case ({trap_valid, go_super})
            2'b11:   state_nx = ST_SUP_TAKEN;
            2'b10:   state_nx = ST_MACH_TAKEN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc    <= '0;
            next_priv  <= PRIV_MACH;
            cause_out  <= '0;
            epc_out    <= '0;
            tval_out   <= '0;
            status_out <= '0;
        end else if (trap_valid) begin
            next_pc    <= go_super ? stvec : mtvec;
            next_priv  <= go_super ? PRIV_SUPER : PRIV_MACH;
            cause_out  <= cause_word;
            epc_out    <= cur_pc;
            tval_out   <= addr_related ? fault_addr : '0;
            status_out <= status_nx;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SUP_TAKEN:  begin out_valid = 1'b1; out_to_super = 1'b1; end
            ST_MACH_TAKEN: begin out_valid = 1'b1; out_to_super = 1'b0; end
            default:       begin out_valid = 1'b0; out_to_super = 1'b0; end
        endcase
    end

endmodule

module trap_entry_unit_chk #(
    parameter int XLEN = 64,
    localparam int CODE_W = $clog2(XLEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_valid,
    input logic              trap_is_irq,
    input logic [1:0]        cur_priv,
    input logic [XLEN-1:0]   cur_pc,
    input logic              out_valid,
    input logic              out_to_super,
    input logic [XLEN-1:0]   next_pc,
    input logic [1:0]        next_priv,
    input logic [XLEN-1:0]   cause_out,
    input logic [XLEN-1:0]   epc_out,
    input logic [XLEN-1:0]   tval_out,
    input logic [XLEN-1:0]   status_out
);

    a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> out_valid);
    a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !out_valid);
    a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> $stable(next_pc) && $stable(cause_out));
    a_r3_irq_msb: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_is_irq |=> cause_out[XLEN-1]);
    a_r6_machine_never_delegates: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && cur_priv == 2'd3 |=> !out_to_super);
    a_r7_super_priv: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_to_super |-> next_priv == 2'd1 && !status_out[1]);
    a_r8_mach_priv: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_to_super |-> next_priv == 2'd3 && !status_out[3]);
    a_r9_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> epc_out == $past(cur_pc));
    a_r10_irq_no_tval: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_is_irq |=> tval_out == '0);

endmodule

bind trap_entry_unit trap_entry_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_valid   (trap_valid),
    .trap_is_irq  (trap_is_irq),
    .cur_priv     (cur_priv),
    .cur_pc       (cur_pc),
    .out_valid    (out_valid),
    .out_to_super (out_to_super),
    .next_pc      (next_pc),
    .next_priv    (next_priv),
    .cause_out    (cause_out),
    .epc_out      (epc_out),
    .tval_out     (tval_out),
    .status_out   (status_out)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;

    localparam int XLEN       = 64;
    localparam int CODE_W     = $clog2(XLEN);
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              trap_valid;
    logic              trap_is_irq;
    logic [CODE_W-1:0] trap_code;
    logic              xlat_fault;
    logic              xlat_on;
    logic [1:0]        xlat_kind;
    logic [XLEN-1:0]   fault_addr, cur_pc, exc_deleg, irq_deleg, stvec, mtvec, status_in;
    logic [1:0]        cur_priv;
    logic              out_valid, out_to_super;
    logic [XLEN-1:0]   next_pc, cause_out, epc_out, tval_out, status_out;
    logic [1:0]        next_priv;

    int tests_run = 0;
    int tests_failed = 0;

    // expected results of the most recent trap
    logic            e_super;
    logic [XLEN-1:0] e_pc, e_cause, e_epc, e_tval, e_status;
    logic [1:0]      e_priv;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .xlat_fault(xlat_fault), .xlat_on(xlat_on),
        .xlat_kind(xlat_kind), .fault_addr(fault_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .stvec(stvec), .mtvec(mtvec), .status_in(status_in), .out_valid(out_valid),
        .out_to_super(out_to_super), .next_pc(next_pc), .next_priv(next_priv),
        .cause_out(cause_out), .epc_out(epc_out), .tval_out(tval_out),
        .status_out(status_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // sets the inputs of one trap and computes its expected result
    task automatic set_trap(input logic irq, input int code, input logic xf,
                            input logic xon, input logic [1:0] kind,
                            input logic [1:0] priv, input logic [XLEN-1:0] pc,
                            input logic [XLEN-1:0] addr);
        int rc;
        logic bit_sel;
        trap_valid  = 1'b1;
        trap_is_irq = irq;
        trap_code   = CODE_W'(code);
        xlat_fault  = xf;
        xlat_on     = xon;
        xlat_kind   = kind;
        cur_priv    = priv;
        cur_pc      = pc;
        fault_addr  = addr;
        if (irq)                   rc = code;
        else if (xf)               rc = (kind == 2'd0) ? (xon ? 12 : 1) :
                                        (kind == 2'd1) ? (xon ? 13 : 5) : (xon ? 15 : 7);
        else if (code == 8)        rc = 8 + int'(priv);
        else                       rc = code;
        bit_sel  = irq ? irq_deleg[rc] : exc_deleg[rc];
        e_super  = (priv <= 2'd1) && bit_sel;
        e_cause  = XLEN'(rc);
        e_cause[XLEN-1] = irq;
        e_epc    = pc;
        e_tval   = (!irq && (rc inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) ? addr : '0;
        e_status = status_in;
        if (e_super) begin
            e_pc = stvec; e_priv = 2'd1;
            e_status[5] = status_in[1]; e_status[8] = priv[0]; e_status[1] = 1'b0;
        end else begin
            e_pc = mtvec; e_priv = 2'd3;
            e_status[7] = status_in[3]; e_status[12:11] = priv; e_status[3] = 1'b0;
        end
    endtask

    task automatic check_trap(input string req);
        chk(req, "out_valid", XLEN'(out_valid), XLEN'(1));
        chk(req, "to_super", XLEN'(out_to_super), XLEN'(e_super));
        chk(req, "next_pc", next_pc, e_pc);
        chk(req, "next_priv", XLEN'(next_priv), XLEN'(e_priv));
        chk(req, "cause", cause_out, e_cause);
        chk(req, "epc", epc_out, e_epc);
        chk(req, "tval", tval_out, e_tval);
        chk(req, "status", status_out, e_status);
    endtask

    // one isolated trap: drive at falling edge, captured at the rising edge, check after
    task automatic one_trap(input string req, input logic irq, input int code,
                            input logic xf, input logic xon, input logic [1:0] kind,
                            input logic [1:0] priv, input logic [XLEN-1:0] pc,
                            input logic [XLEN-1:0] addr);
        @(negedge clk);
        set_trap(irq, code, xf, xon, kind, priv, pc, addr);
        @(negedge clk);
        trap_valid = 1'b0;
        check_trap(req);
    endtask

    task automatic t_reset;
        chk("R1", "out_valid", XLEN'(out_valid), '0);
        chk("R1", "to_super", XLEN'(out_to_super), '0);
        chk("R1", "next_priv", XLEN'(next_priv), XLEN'(3));
        chk("R1", "next_pc", next_pc, '0);
        chk("R1", "cause", cause_out, '0);
        chk("R1", "epc", epc_out, '0);
        chk("R1", "tval", tval_out, '0);
        chk("R1", "status", status_out, '0);
    endtask

    task automatic t_ecall;
        // R4 R6 R7: user call delegated (bit 8 set)
        one_trap("R4", 1'b0, 8, 1'b0, 1'b0, 2'd0, 2'd0, 64'h0000_0000_8000_1000, 64'hDEAD);
        // R4 R8: supervisor call, bit 9 clear -> machine
        one_trap("R4", 1'b0, 8, 1'b0, 1'b0, 2'd0, 2'd1, 64'hFFFF_FFFF_C000_0040, 64'hBEEF);
        // R4 R6: machine call never delegated even with bit 11 set
        one_trap("R6", 1'b0, 8, 1'b0, 1'b0, 2'd0, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0);
    endtask

    task automatic t_irq_vs_exc;
        // R3 R6 R10: interrupt 5 delegated by irq mask, tval zero
        one_trap("R3", 1'b1, 5, 1'b0, 1'b0, 2'd0, 2'd0, 64'h2000, 64'hFFFF_0000_1111_2222);
        // R6 R10: exception 5 uses exc mask (bit clear) -> machine, tval = addr
        one_trap("R10", 1'b0, 5, 1'b0, 1'b0, 2'd0, 2'd1, 64'h2004, 64'hFFFF_0000_1111_2222);
        // R10: illegal instruction code 2 gets zero tval
        one_trap("R10", 1'b0, 2, 1'b0, 1'b0, 2'd0, 2'd0, 64'h2008, 64'h5555);
        // R6: reserved privilege goes to machine
        one_trap("R6", 1'b1, 9, 1'b0, 1'b0, 2'd0, 2'd2, 64'h200C, 64'h0);
    endtask

    task automatic t_xlat;
        // R5: trap_code ignored, codes from kind and mode
        for (int k = 0; k < 4; k++) begin
            one_trap("R5", 1'b0, 2, 1'b1, 1'b1, 2'(k), 2'd0, 64'h3000 + 64'(k), 64'hA5A5_0000 + 64'(k));
            one_trap("R5", 1'b0, 2, 1'b1, 1'b0, 2'(k), 2'd1, 64'h3100 + 64'(k), 64'h5A5A_0000 + 64'(k));
        end
    endtask

    task automatic t_hold;
        logic [XLEN-1:0] pc_s, cause_s;
        pc_s = next_pc; cause_s = cause_out;
        repeat (3) @(negedge clk);
        chk("R2", "idle valid", XLEN'(out_valid), '0);
        chk("R2", "hold pc", next_pc, pc_s);
        chk("R2", "hold cause", cause_out, cause_s);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        set_trap(1'b0, 8, 1'b0, 1'b0, 2'd0, 2'd0, 64'h4000, 64'h0);
        @(negedge clk);
        check_trap("R2");
        set_trap(1'b1, 7, 1'b0, 1'b0, 2'd0, 2'd1, 64'h4004, 64'h9);
        @(negedge clk);
        trap_valid = 1'b0;
        check_trap("R2");
        @(negedge clk);
        chk("R2", "valid drops", XLEN'(out_valid), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trap_valid = 1'b0; trap_is_irq = 1'b0; trap_code = '0;
        xlat_fault = 1'b0; xlat_on = 1'b0; xlat_kind = '0; fault_addr = '0;
        cur_pc = '0; cur_priv = '0;
        exc_deleg = 64'h0000_0000_0000_0900; // bits 8 and 11 set
        irq_deleg = 64'h0000_0000_0000_0220; // bits 5 and 9 set
        stvec = 64'hFFFF_FFFF_8000_0100;
        mtvec = 64'h0000_0000_8000_0000;
        status_in = 64'hA000_0000_0000_002A; // SIE=1, MIE=1, SPIE=1, MPIE=0
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_ecall;
        t_irq_vs_exc;
        status_in = 64'h0000_0000_0000_1980; // SIE=0, MIE=0, MPIE=1, SPP=1, MPP=3
        t_xlat;
        t_hold;
        t_back_to_back;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule